// File: doc/BRIEF.md
# Sensor Result Register Bank with Read Lock

This block is the register bank that sits behind a byte-wide bus slave in a three-axis field sensor. A host reaches it through byte transfers. Each transaction begins with a start pulse. In a write transaction the first byte sets an internal address pointer, and the bytes after it write the configuration registers. Read bytes come from the pointer location, and the pointer then advances. When the pointer leaves the last result byte it steps back to the first result byte, so a host can poll the three axes without re-addressing.

The measurement path delivers three signed 16-bit results with a single strobe. A host may read only part of the six result bytes, or it may read the mode register. In either case the bank locks, so the set being read is never torn. A result that arrives during the lock is parked in a one-entry holding slot, and a newer arrival replaces it. The parked result is committed once the lock is released. A status byte reports the ready and lock flags. Three fixed identification bytes let the host recognise the part. The bit-level two-wire physical layer is outside this block.

Top module: `sensor_regbank`

## Requirements
- R1: After reset the outputs are cfg_a=0x10, cfg_b=0x20, mode=0x01, data_ready=0 and data_lock=0, and addresses 10, 11 and 12 read 0x48, 0x34 and 0x33.
- R2: After xfer_start, the first written byte loads the pointer. A transaction that carries only that byte moves the pointer and changes no register.
- R3: The pointer advances by one after every read byte and after every written data byte, so consecutive bytes reach consecutive addresses. Address 0 is cfg_a, 1 is cfg_b and 2 is mode.
- R4: Reading address 8 moves the pointer to address 3.
- R5: Reading any address above 12 returns 0x00. Writes to addresses 3 to 12 and above 12 change nothing.
- R6: Undefined bits are forced to zero on write: cfg_a bit 7, cfg_b bits 4:0 and mode bits 7:2.
- R7: A result taken while unlocked is visible at the first edge. Addresses 3 to 8 hold X high, X low, Z high, Z low, Y high, Y low.
- R8: On a commit, data_ready reads 0 after the commit edge and 1 after the next edge. Address 9 reads {6'b0, lock, ready}.
- R9: data_lock sets when one to five of the six result bytes have been read, or when mode has been read. It clears once all six bytes have been read, and also on any write to mode or to cfg_a.
- R10: Results that arrive while locked leave addresses 3 to 8 unchanged. The latest of them is committed at the first edge after data_lock reads 0.
- R11: A commit while mode[1:0]=01 (single conversion) sets mode to 0x82. This is the idle code 10 with bit 7 marking completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start of a bus transaction; the next written byte is an address |
| wr_en | input | 1 | Write byte strobe |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read byte strobe (ignored when wr_en is high) |
| rd_data | output | 8 | Byte read, valid after the edge that takes rd_en |
| meas_valid | input | 1 | New result strobe from the measurement path |
| meas_x | input | 16 | X result |
| meas_y | input | 16 | Y result |
| meas_z | input | 16 | Z result |
| cfg_a | output | 8 | Configuration A (rate, averaging, bias) |
| cfg_b | output | 8 | Configuration B (gain) |
| mode | output | 8 | Mode register |
| data_ready | output | 1 | Ready flag |
| data_lock | output | 1 | Lock flag |

## Verification
Every read byte is registered. rd_data is therefore due at the edge that samples rd_en, and the bench drives on one falling edge and reads on the next. A direct commit changes the result bytes and clears data_ready at the edge that samples meas_valid, and data_ready returns one edge later. The bench samples data_ready at those two falling edges. A parked result follows the lock. The lock drops at the edge of the sixth read, the commit lands one edge after that, and ready rises one edge later still. The pending scenario checks each of those three falling edges in order.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int BYTE_W     = 8;
  localparam int RES_FIRST  = 3;
  localparam int RES_LAST   = 8;
  localparam int ADDR_STAT  = 9;
  localparam int ADDR_ID0   = 10;
  localparam int ADDR_TOP   = 12;

  // pointer step after an access: last result byte wraps to the first
  function automatic logic [7:0] ptr_step(input logic [7:0] p);
    return (p == 8'(RES_LAST)) ? 8'(RES_FIRST) : p + 8'd1;
  endfunction

  function automatic logic is_result(input logic [7:0] a);
    return (a >= 8'(RES_FIRST)) && (a <= 8'(RES_LAST));
  endfunction

  function automatic logic [2:0] slot_of(input logic [7:0] a);
    logic [7:0] d;
    d = a - 8'(RES_FIRST);
    return d[2:0];
  endfunction

  // identification bytes: 'H', '4', '3'
  function automatic logic [7:0] id_byte(input logic [7:0] a);
    case (a)
      8'd10:   return 8'h48;
      8'd11:   return 8'h34;
      8'd12:   return 8'h33;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sreg_pointer.sv
module sreg_pointer
  import sreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_start,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] ptr,
  output logic       reg_wr,
  output logic       reg_rd
);
  logic addr_phase;

  assign reg_wr = wr_en && !addr_phase;
  assign reg_rd = rd_en && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= 8'd0;
      addr_phase <= 1'b0;
    end else if (xfer_start) begin
      addr_phase <= 1'b1;
    end else if (wr_en && addr_phase) begin
      ptr        <= wr_data;
      addr_phase <= 1'b0;
    end else if (reg_wr || reg_rd) begin
      ptr        <= ptr_step(ptr);
      addr_phase <= 1'b0;
    end
  end
endmodule

// File: rtl/sreg_lock.sv
module sreg_lock #(
  parameter int SLOTS = 6,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_rd,
  input  logic [IW-1:0] slot_idx,
  input  logic          mode_rd,
  input  logic          lock_clr,
  output logic          lock,
  output logic          full_read
);
  localparam logic [SLOTS-1:0] ALL = '1;
  localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [SLOTS-1:0] seen, seen_nx;
  logic             mode_hold;

  always_comb begin
    seen_nx   = seen | (slot_rd ? (ONE << slot_idx) : '0);
    full_read = slot_rd && (seen_nx == ALL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || lock_clr || full_read) begin
      seen      <= '0;
      mode_hold <= 1'b0;
    end else begin
      seen <= seen_nx;
      if (mode_rd) mode_hold <= 1'b1;
    end
  end

  assign lock = (|seen) || mode_hold;
endmodule

// File: rtl/sreg_results.sv
module sreg_results #(
  parameter int W  = 16,
  parameter int CH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic [CH-1:0][W-1:0] upd_val,
  input  logic                 lock,
  output logic                 commit,
  output logic                 pend_valid,
  output logic                 ready,
  output logic [CH-1:0][W-1:0] res
);
  logic [CH-1:0][W-1:0] pend;
  logic                 take_new, take_pend, rdy_arm;

  assign take_new  = upd_valid && !lock;
  assign take_pend = !upd_valid && pend_valid && !lock;
  assign commit    = take_new || take_pend;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res[c]  <= '0;
        pend[c] <= '0;
      end else begin
        if (upd_valid && lock) pend[c] <= upd_val[c];
        if (take_new)       res[c] <= upd_val[c];
        else if (take_pend) res[c] <= pend[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      ready      <= 1'b0;
      rdy_arm    <= 1'b0;
    end else begin
      if (upd_valid && lock) pend_valid <= 1'b1;
      else if (commit)       pend_valid <= 1'b0;
      rdy_arm <= commit;
      if (commit)       ready <= 1'b0;
      else if (rdy_arm) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
  import sreg_pkg::*;
#(
  parameter int         RES_W     = 16,
  parameter logic [7:0] CFG_A_RST = 8'h10,
  parameter logic [7:0] CFG_B_RST = 8'h20,
  parameter logic [7:0] MODE_RST  = 8'h01,
  localparam int        CH        = 3,
  localparam int        SLOTS     = 2 * CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             meas_valid,
  input  logic [RES_W-1:0] meas_x,
  input  logic [RES_W-1:0] meas_y,
  input  logic [RES_W-1:0] meas_z,
  output logic [7:0]       cfg_a,
  output logic [7:0]       cfg_b,
  output logic [7:0]       mode,
  output logic             data_ready,
  output logic             data_lock
);
  localparam logic [7:0] MASK_A    = 8'h7F;
  localparam logic [7:0] MASK_B    = 8'hE0;
  localparam logic [7:0] MASK_MODE = 8'h03;
  localparam logic [7:0] MODE_DONE = 8'h82;

  // event wires, also watched by the checker
  logic [7:0]              ptr;
  logic                    reg_wr, reg_rd, commit, pend_valid, full_read;
  logic                    slot_rd, mode_rd, lock_clr;
  logic [2:0]              slot_idx;
  logic [CH-1:0][RES_W-1:0] res;
  logic [7:0]              rd_mux;

  sreg_pointer u_ptr (
    .clk, .rst_n, .xfer_start, .wr_en, .wr_data, .rd_en,
    .ptr, .reg_wr, .reg_rd
  );

  assign slot_rd  = reg_rd && is_result(ptr);
  assign slot_idx = slot_of(ptr);
  assign mode_rd  = reg_rd && (ptr == 8'd2);
  assign lock_clr = reg_wr && ((ptr == 8'd0) || (ptr == 8'd2));

  sreg_lock #(.SLOTS(SLOTS)) u_lock (
    .clk, .rst_n, .slot_rd, .slot_idx, .mode_rd, .lock_clr,
    .lock(data_lock), .full_read
  );

  // channel order in the bank: X, Z, Y
  sreg_results #(.W(RES_W), .CH(CH)) u_res (
    .clk, .rst_n,
    .upd_valid(meas_valid),
    .upd_val({meas_y, meas_z, meas_x}),
    .lock(data_lock),
    .commit, .pend_valid,
    .ready(data_ready),
    .res
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_a <= CFG_A_RST;
      cfg_b <= CFG_B_RST;
      mode  <= MODE_RST;
    end else begin
      if (reg_wr && ptr == 8'd0) cfg_a <= wr_data & MASK_A;
      if (reg_wr && ptr == 8'd1) cfg_b <= wr_data & MASK_B;
      if (reg_wr && ptr == 8'd2) mode <= wr_data & MASK_MODE;
      else if (commit && mode[1:0] == 2'b01) mode <= MODE_DONE;
    end
  end

  always_comb begin
    logic [RES_W-1:0] word;
    word   = res[slot_idx[2:1]];
    rd_mux = 8'h00;
    if (ptr == 8'd0)                    rd_mux = cfg_a;
    else if (ptr == 8'd1)               rd_mux = cfg_b;
    else if (ptr == 8'd2)               rd_mux = mode;
    else if (is_result(ptr))            rd_mux = slot_idx[0] ? word[7:0] : word[15:8];
    else if (ptr == 8'(ADDR_STAT))      rd_mux = {6'b0, data_lock, data_ready};
    else if (ptr >= 8'(ADDR_ID0) && ptr <= 8'(ADDR_TOP)) rd_mux = id_byte(ptr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= 8'h00;
    else if (reg_rd) rd_data <= rd_mux;
  end
endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
  parameter int RES_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         ptr,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic               commit,
  input logic               pend_valid,
  input logic               meas_valid,
  input logic               data_lock,
  input logic               data_ready,
  input logic [7:0]         cfg_b,
  input logic [7:0]         mode,
  input logic [3*RES_W-1:0] res
);
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && ptr == 8'd8) |=> (ptr == 8'd3));

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !data_ready);

  assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(commit, 2));

  assert_lock_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (ptr == 8'd0 || ptr == 8'd2)) |=> !data_lock);

  assert_locked_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_lock |=> $stable(res));

  assert_pend_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !data_lock && !meas_valid) |=> !pend_valid);

  assert_cfgb_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_b[4:0] == 5'd0);

  assert_mode_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode[6:2] == 5'd0);
endmodule

bind sensor_regbank sreg_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr(ptr), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .commit(commit), .pend_valid(pend_valid), .meas_valid(meas_valid),
  .data_lock(data_lock), .data_ready(data_ready), .cfg_b(cfg_b),
  .mode(mode), .res(res)
);

// File: tb/sensor_regbank_tb.sv
module sensor_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0, wr_en = 1'b0, rd_en = 1'b0, meas_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [15:0] meas_x = '0, meas_y = '0, meas_z = '0;
  logic [7:0]  rd_data, cfg_a, cfg_b, mode;
  logic        data_ready, data_lock;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  sensor_regbank dut_i (
    .clk, .rst_n, .xfer_start, .wr_en, .wr_data, .rd_en, .rd_data,
    .meas_valid, .meas_x, .meas_y, .meas_z,
    .cfg_a, .cfg_b, .mode, .data_ready, .data_lock
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic tx_start();
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; b = rd_data;
  endtask

  task automatic aim(input logic [7:0] a);
    tx_start(); put(a);
  endtask

  task automatic push(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    meas_x = x; meas_y = y; meas_z = z; meas_valid = 1'b1;
    @(negedge clk); meas_valid = 1'b0;
  endtask

  // expected bytes at 3..8: X hi, X lo, Z hi, Z lo, Y hi, Y lo
  task automatic read_set(input string req, input logic [15:0] x, input logic [15:0] y,
                          input logic [15:0] z);
    logic [7:0] b;
    logic [7:0] exp [6];
    exp = '{x[15:8], x[7:0], z[15:8], z[7:0], y[15:8], y[7:0]};
    aim(8'd3);
    for (int i = 0; i < 6; i++) begin
      get(b);
      chk_eq(req, b, exp[i]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk_eq("R1 cfg_a", cfg_a, 8'h10);
    chk_eq("R1 cfg_b", cfg_b, 8'h20);
    chk_eq("R1 mode", mode, 8'h01);
    chk_eq("R1 ready", data_ready, 0);
    chk_eq("R1 lock", data_lock, 0);
    aim(8'd10);
    get(b); chk_eq("R1 id0", b, 8'h48);
    get(b); chk_eq("R1 id1", b, 8'h34);
    get(b); chk_eq("R1 id2", b, 8'h33);
  endtask

  task automatic t_pointer();
    logic [7:0] b;
    aim(8'd1);                      // R2: address only
    chk_eq("R2 cfg_b untouched", cfg_b, 8'h20);
    get(b); chk_eq("R2 pointer loaded", b, 8'h20);
    aim(8'd0);
    get(b); chk_eq("R3 read addr0", b, 8'h10);
    get(b); chk_eq("R3 read addr1", b, 8'h20);
    tx_start(); put(8'd0); put(8'h55); put(8'hE7);
    chk_eq("R3 cfg_a write", cfg_a, 8'h55);
    chk_eq("R6 cfg_b low bits", cfg_b, 8'hE0);
    tx_start(); put(8'd0); put(8'hFF);
    chk_eq("R6 cfg_a bit7", cfg_a, 8'h7F);
    tx_start(); put(8'd2); put(8'hFF);
    chk_eq("R6 mode upper bits", mode, 8'h03);
    tx_start(); put(8'd0); put(8'h10); put(8'h20); put(8'h00);
    chk_eq("R3 mode via increment", mode, 8'h00);
  endtask

  task automatic t_invalid();
    logic [7:0] b;
    aim(8'd13); get(b); chk_eq("R5 read 13", b, 8'h00);
    aim(8'h40); get(b); chk_eq("R5 read 0x40", b, 8'h00);
    tx_start(); put(8'd10); put(8'h00);
    aim(8'd10); get(b); chk_eq("R5 write id ignored", b, 8'h48);
    tx_start(); put(8'h20); put(8'hAA);
    chk_eq("R5 write 0x20 cfg_a", cfg_a, 8'h10);
    chk_eq("R5 write 0x20 cfg_b", cfg_b, 8'h20);
    chk_eq("R5 write 0x20 mode", mode, 8'h00);
  endtask

  task automatic t_commit();
    logic [7:0] b;
    push(16'h1234, 16'hABCD, 16'h0F0E);
    chk_eq("R8 ready low after commit", data_ready, 0);
    @(negedge clk);
    chk_eq("R8 ready high next edge", data_ready, 1);
    aim(8'd9); get(b); chk_eq("R8 status", b, 8'h01);
    aim(8'd3);
    get(b); chk_eq("R7 X hi", b, 8'h12);
    chk_eq("R9 lock after partial", data_lock, 1);
    get(b); chk_eq("R7 X lo", b, 8'h34);
    get(b); chk_eq("R7 Z hi", b, 8'h0F);
    get(b); chk_eq("R7 Z lo", b, 8'h0E);
    get(b); chk_eq("R7 Y hi", b, 8'hAB);
    get(b); chk_eq("R7 Y lo", b, 8'hCD);
    chk_eq("R9 lock clears on full read", data_lock, 0);
    get(b); chk_eq("R4 wrap to addr3", b, 8'h12);
    chk_eq("R9 relock", data_lock, 1);
    tx_start(); put(8'd0); put(8'h10);
    chk_eq("R9 cfg_a write clears lock", data_lock, 0);
    tx_start(); put(8'd3); put(8'h99);
    aim(8'd3); get(b); chk_eq("R5 result write ignored", b, 8'h12);
    tx_start(); put(8'd0); put(8'h10);
    chk_eq("R9 lock cleared again", data_lock, 0);
  endtask

  task automatic t_pending();
    logic [7:0] b;
    aim(8'd3); get(b); chk_eq("R10 first byte", b, 8'h12);
    push(16'h1111, 16'h1111, 16'h1111);
    push(16'h2222, 16'h3333, 16'h4444);
    @(negedge clk);
    chk_eq("R10 no commit while locked", data_ready, 1);
    get(b); chk_eq("R10 old X lo", b, 8'h34);
    get(b); chk_eq("R10 old Z hi", b, 8'h0F);
    get(b); chk_eq("R10 old Z lo", b, 8'h0E);
    get(b); chk_eq("R10 old Y hi", b, 8'hAB);
    get(b); chk_eq("R10 old Y lo", b, 8'hCD);
    chk_eq("R9 unlocked", data_lock, 0);
    @(negedge clk);
    chk_eq("R10 pending committed ready low", data_ready, 0);
    @(negedge clk);
    chk_eq("R10 ready after pending", data_ready, 1);
    read_set("R10 newest kept", 16'h2222, 16'h3333, 16'h4444);
    aim(8'd2); get(b); chk_eq("R9 mode read", b, 8'h00);
    chk_eq("R9 mode read locks", data_lock, 1);
    tx_start(); put(8'd2); put(8'h00);
    chk_eq("R9 mode write clears lock", data_lock, 0);
  endtask

  task automatic t_single();
    tx_start(); put(8'd2); put(8'h01);
    push(16'h0001, 16'h0002, 16'h0003);
    chk_eq("R11 mode after single", mode, 8'h82);
    chk_eq("R8 ready low", data_ready, 0);
    @(negedge clk);
    chk_eq("R8 ready high", data_ready, 1);
    read_set("R11 data", 16'h0001, 16'h0002, 16'h0003);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_invalid();
    t_commit();
    t_pending();
    t_single();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule